// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues management frames on a two-wire serial management interface (a clock line and a shared bidirectional data line) to read and write PHY registers. A host raises a one-cycle start strobe together with a 5-bit PHY address, a 5-bit register address, a read/write select, 16 bits of write data and a preamble option. The block latches these fields, shifts the frame out bit by bit on a divided management clock, and ends with a one-cycle done pulse. For reads it also presents the 16-bit register value.

The management clock comes from the system clock through a divider. Each bit slot is one low half-period followed by one high half-period, each lasting `HALF_DIV` system cycles. Outgoing data changes only at the start of a low half. Incoming data is sampled on the last system cycle of a low half, just before the clock rises. The data-line output enable is low in every slot where the block lets go of the line. This allows a PHY to drive the line during those slots.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, `mdc_o`, `mdio_oe_o`, `busy_o` and `done_o` are low and `rdata_o` is zero.
- R2: While busy, every bit slot holds `mdc_o` low for `HALF_DIV` cycles and then high for `HALF_DIV` cycles. The first low half starts in the cycle after the start strobe is accepted. The default of 10 keeps the management clock at 2.5 MHz for a 50 MHz system clock. When not busy, `mdc_o` stays low.
- R3: With `pre_en_i` high at acceptance, the frame opens with 32 slots that drive a one with the output enable high. With `pre_en_i` low, no such slots are sent.
- R4: A read sends 16 command bits, most significant first, with the output enable high. The command word is the low 16 bits of (0xF6 << 10) | (phy << 5) | reg.
- R5: After the read command, 20 released slots follow with `mdio_oe_o` low and `mdio_o` low. `mdio_i` is captured in each of them on the last system cycle of the low half. The first captured bit is the most significant bit of a 20-bit word.
- R6: The read result is the 20-bit captured word shifted right by one and masked to 16 bits.
- R7: A write sends 32 bits, most significant first, with the output enable high. The word is (0x5002 << 16) | (phy << 23) | (reg << 18) | data. Two released slots follow, with `mdio_oe_o` low.
- R8: `done_o` is high for exactly one cycle, the cycle after the last high half ends. In that same cycle `busy_o` falls. `rdata_o` takes the new value only then and only for reads. A write leaves it unchanged.
- R9: A start strobe is accepted only when `busy_o` is low, and a strobe in the done cycle is accepted. The fields are latched at acceptance. A strobe or field change while busy has no effect on the frame in flight.
- R10: `mdio_o` and `mdio_oe_o` change only at the start of a low half. They never change while `mdc_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request strobe |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| pre_en_i | input | 1 | Send 32-one preamble before the frame |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| mdio_i | input | 1 | Sampled data line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Driven data value |
| mdio_oe_o | output | 1 | Data line output enable |

## Verification
All outputs are registered. The first low half of a frame shows one cycle after the accepting edge, and each slot takes 2*HALF_DIV cycles. The done pulse and the new read value appear exactly 2*HALF_DIV*N+1 cycles after the strobe cycle, where N counts preamble, command and released slots. The bench turns every accepted request into a queue of per-cycle expectations at the moment of acceptance. It pops one entry at each falling clock edge, when the registered outputs are settled, and compares it against the outputs. The same entry supplies the PHY model's line value, so that value is in place at the rising edge where the design samples it.

// File: rtl/mdio_fm_pkg.sv
package mdio_fm_pkg;
  localparam int unsigned PHY_W      = 5;
  localparam int unsigned REG_W      = 5;
  localparam int unsigned DAT_W      = 16;
  localparam int unsigned RD_CMD_LEN = 16;
  localparam int unsigned WR_CMD_LEN = 32;
  localparam int unsigned RD_REL_LEN = 20;
  localparam int unsigned WR_REL_LEN = 2;

  // read command: two leading ones, start 01, opcode 10, phy, reg
  function automatic logic [RD_CMD_LEN-1:0] rd_cmd(input logic [PHY_W-1:0] phy,
                                                   input logic [REG_W-1:0] regad);
    return {2'b11, 2'b01, 2'b10, phy, regad};
  endfunction

  // write command: start 01, opcode 01, phy, reg, turnaround 10, data
  function automatic logic [WR_CMD_LEN-1:0] wr_cmd(input logic [PHY_W-1:0] phy,
                                                   input logic [REG_W-1:0] regad,
                                                   input logic [DAT_W-1:0] data);
    return {2'b01, 2'b01, phy, regad, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
  parameter int unsigned HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word;
    if (clr)           word_d = '0;
    else if (shift_en) word_d = {word[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_d;
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_fm_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  rd_i,
  input  logic                  pre_en_i,
  input  logic [PHY_W-1:0]      phy_addr_i,
  input  logic [REG_W-1:0]      reg_addr_i,
  input  logic [DAT_W-1:0]      wdata_i,
  input  logic                  tick,
  input  logic [RD_REL_LEN-1:0] cap_word,
  output logic                  cap_clr,
  output logic                  cap_shift,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [DAT_W-1:0]      rdata_o,
  output logic                  mdc_o,
  output logic                  mdio_o,
  output logic                  mdio_oe_o
);
  localparam int unsigned SHW   = PRE_LEN + WR_CMD_LEN;
  localparam int unsigned CNT_W = $clog2(SHW + 1);

  logic             busy_q, busy_d, done_q, done_d, mdc_q, mdc_d;
  logic             oe_q, oe_d, rd_q, rd_d;
  logic [SHW-1:0]   sh_q, sh_d;
  logic [CNT_W-1:0] drv_q, drv_d, rel_q, rel_d;
  logic [DAT_W-1:0] rdat_q, rdat_d;
  logic             accept;
  logic [WR_CMD_LEN-1:0] frame;
  logic [CNT_W-1:0] cmd_len;

  assign accept    = start_i && !busy_q;
  assign frame     = rd_i ? {rd_cmd(phy_addr_i, reg_addr_i), {(WR_CMD_LEN-RD_CMD_LEN){1'b0}}}
                          : wr_cmd(phy_addr_i, reg_addr_i, wdata_i);
  assign cmd_len   = rd_i ? CNT_W'(RD_CMD_LEN) : CNT_W'(WR_CMD_LEN);
  assign cap_clr   = accept;
  assign cap_shift = busy_q && tick && !mdc_q && !oe_q && rd_q;

  always_comb begin
    busy_d = busy_q; done_d = 1'b0; mdc_d = mdc_q; oe_d = oe_q; rd_d = rd_q;
    sh_d = sh_q; drv_d = drv_q; rel_d = rel_q; rdat_d = rdat_q;
    if (accept) begin
      busy_d = 1'b1;
      mdc_d  = 1'b0;
      oe_d   = 1'b1;
      rd_d   = rd_i;
      rel_d  = rd_i ? CNT_W'(RD_REL_LEN) : CNT_W'(WR_REL_LEN);
      if (pre_en_i) begin
        sh_d  = {{PRE_LEN{1'b1}}, frame};
        drv_d = CNT_W'(PRE_LEN) + cmd_len;
      end else begin
        sh_d  = {frame, {PRE_LEN{1'b0}}};
        drv_d = cmd_len;
      end
    end else if (busy_q && tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
      end else begin
        mdc_d = 1'b0;
        if (drv_q != '0) begin
          sh_d  = sh_q << 1;
          drv_d = drv_q - 1'b1;
          if (drv_q == CNT_W'(1)) oe_d = 1'b0;
        end else begin
          rel_d = rel_q - 1'b1;
          if (rel_q == CNT_W'(1)) begin
            busy_d = 1'b0;
            done_d = 1'b1;
            oe_d   = 1'b0;
            if (rd_q) rdat_d = cap_word[DAT_W:1];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; mdc_q <= 1'b0; oe_q <= 1'b0; rd_q <= 1'b0;
      sh_q <= '0; drv_q <= '0; rel_q <= '0; rdat_q <= '0;
    end else begin
      busy_q <= busy_d; done_q <= done_d; mdc_q <= mdc_d; oe_q <= oe_d; rd_q <= rd_d;
      sh_q <= sh_d; drv_q <= drv_d; rel_q <= rel_d; rdat_q <= rdat_d;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rdat_q;
  assign mdc_o     = mdc_q;
  assign mdio_o    = sh_q[SHW-1];
  assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_fm_pkg::*;
#(
  parameter int unsigned HALF_DIV = 10,
  parameter int unsigned PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              pre_en_i,
  input  logic [PHY_W-1:0]  phy_addr_i,
  input  logic [REG_W-1:0]  reg_addr_i,
  input  logic [DAT_W-1:0]  wdata_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DAT_W-1:0]  rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic                  tick, cap_clr, cap_shift;
  logic [RD_REL_LEN-1:0] cap_word;

  mdc_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy_o), .tick(tick)
  );

  mdio_capture #(.W(RD_REL_LEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(cap_clr), .shift_en(cap_shift),
    .din(mdio_i), .word(cap_word)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .pre_en_i(pre_en_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .tick(tick), .cap_word(cap_word), .cap_clr(cap_clr), .cap_shift(cap_shift),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );
endmodule

module mdio_frame_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdc_o && !mdio_oe_o));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rdata_o));
  p_line_steady_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
  p_release_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe_o) |-> !mdc_o);
  p_start_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind mdio_frame_master mdio_frame_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .rdata_o(rdata_o), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, rd_i = 1'b0, pre_en_i = 1'b0, mdio_i = 1'b1;
  logic [4:0]  phy_addr_i = '0, reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
  logic [15:0] rdata_o;

  always #10 clk = ~clk;

  mdio_frame_master #(.HALF_DIV(H)) i_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .pre_en_i(pre_en_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .mdio_i(mdio_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  // entry: [20] done, [19] mdc, [18] oe, [17] mdo, [16] din, [15:0] rdata
  logic [20:0] q[$];
  string       qt[$];
  int          n_chk = 0, n_bad = 0;
  logic [15:0] cur_rd = '0, plan_rd = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_slot(input bit oe, input bit mdo, input bit din, input string tg);
    for (int i = 0; i < 2*H; i++) begin
      q.push_back({1'b0, (i >= H), oe, mdo, din, 16'h0});
      qt.push_back(tg);
    end
  endtask

  task automatic plan(input bit rd, input bit pre, input logic [4:0] phy,
                      input logic [4:0] ra, input logic [15:0] wd, input logic [19:0] pat);
    logic [31:0] w;
    logic [15:0] r;
    if (pre) for (int i = 0; i < 32; i++) push_slot(1'b1, 1'b1, 1'b1, "R3");
    if (rd) begin
      r = 16'((32'hF6 << 10) | (32'(phy) << 5) | 32'(ra));
      for (int i = 15; i >= 0; i--) push_slot(1'b1, r[i], 1'b1, "R4");
      for (int i = 19; i >= 0; i--) push_slot(1'b0, 1'b0, pat[i], "R5");
      plan_rd = 16'((pat >> 1) & 20'hFFFF);
      q.push_back({1'b1, 4'b0, plan_rd});
      qt.push_back("R6");
    end else begin
      w = (32'h5002 << 16) | (32'(phy) << 23) | (32'(ra) << 18) | 32'(wd);
      for (int i = 31; i >= 0; i--) push_slot(1'b1, w[i], 1'b1, "R7");
      for (int i = 0; i < 2; i++) push_slot(1'b0, 1'b0, 1'b1, "R7");
      q.push_back({1'b1, 4'b0, plan_rd});
      qt.push_back("R8");
    end
  endtask

  task automatic step();
    logic [20:0] e;
    string tg;
    bit have;
    @(negedge clk);
    have = (q.size() > 0);
    if (have) begin e = q.pop_front(); tg = qt.pop_front(); end
    else begin e = '0; tg = "R9"; end
    if (have && e[20]) begin
      cur_rd = e[15:0];
      chk(done_o === 1'b1, "R8", "done", int'(done_o), 1);
      chk(busy_o === 1'b0, "R8", "busy", int'(busy_o), 0);
      chk(mdc_o === 1'b0, "R2", "mdc", int'(mdc_o), 0);
      chk(mdio_oe_o === 1'b0, tg, "oe", int'(mdio_oe_o), 0);
    end else begin
      chk(done_o === 1'b0, "R8", "done", int'(done_o), 0);
      chk(busy_o === have, "R9", "busy", int'(busy_o), int'(have));
      chk(mdc_o === e[19], "R2", "mdc", int'(mdc_o), int'(e[19]));
      chk(mdio_oe_o === e[18], e[19] ? "R10" : tg, "oe", int'(mdio_oe_o), int'(e[18]));
      if (e[18] || have)
        chk(mdio_o === e[17], e[19] ? "R10" : tg, "mdio", int'(mdio_o), int'(e[17]));
    end
    chk(rdata_o === cur_rd, (have && e[20]) ? tg : "R8", "rdata", int'(rdata_o), int'(cur_rd));
    mdio_i = (have && !e[20]) ? e[16] : 1'b1;
  endtask

  task automatic request(input bit rd, input bit pre, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd, input logic [19:0] pat);
    rd_i = rd; pre_en_i = pre; phy_addr_i = phy; reg_addr_i = ra; wdata_i = wd;
    start_i = 1'b1;
    if (q.size() == 0) plan(rd, pre, phy, ra, wd, pat);
    step();
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mdc_o === 1'b0, "R1", "mdc", int'(mdc_o), 0);
    chk(mdio_oe_o === 1'b0, "R1", "oe", int'(mdio_oe_o), 0);
    chk(busy_o === 1'b0, "R1", "busy", int'(busy_o), 0);
    chk(done_o === 1'b0, "R1", "done", int'(done_o), 0);
    chk(rdata_o === 16'h0, "R1", "rdata", int'(rdata_o), 0);
    rst_n = 1'b1;
    repeat (4) step();

    request(1'b1, 1'b1, 5'h01, 5'h02, 16'h0, 20'hA5A5B);   // read with preamble
    drain();
    repeat (3) step();
    request(1'b1, 1'b0, 5'h1F, 5'h1F, 16'h0, 20'hFFFFF);   // read, no preamble
    drain();
    request(1'b0, 1'b1, 5'h12, 5'h0D, 16'hBEEF, 20'h0);     // write back-to-back
    drain();
    request(1'b0, 1'b0, 5'h00, 5'h00, 16'h0000, 20'h0);     // write, no preamble
    drain();
    request(1'b1, 1'b0, 5'h0A, 5'h15, 16'h0, 20'h40002);    // R6 edge bits masked
    repeat (30) step();
    // R9: strobe and new fields while busy are ignored
    request(1'b0, 1'b1, 5'h1F, 5'h00, 16'h1234, 20'h0);
    repeat (5) step();
    rd_i = 1'b0; phy_addr_i = 5'h03; wdata_i = 16'h5555;
    drain();
    request(1'b1, 1'b1, 5'h15, 5'h0A, 16'h0, 20'h1FFFE);
    drain();
    repeat (4) step();
    summary();
    $finish;
  end
endmodule